// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Model

This block is a clocked, synthesizable stand-in for a byte-wide, UV-erasable programmable read-only memory. A system or programmer testbench can drive it with the same control lines that the real part uses. The lines are an active-low chip enable, an active-low output enable, a flag for the programming supply and a flag that selects the identification code. Analog levels and nanosecond timing are not modelled. Access delays are counted in clock cycles instead.

The operating mode is decoded from the four control inputs. The decoded modes are standby, output-disabled, read, identification read, program, program-verify and program-inhibit. A program cycle can only clear bits: the stored byte is ANDed with the data input. An erase strobe returns every location to all ones. Reset also leaves the array in that erased state, so the model starts out as a part that has just been delivered.

The array outputs are registered. The enable for an external tri-state buffer goes high one edge after both enables are sampled low. The valid flag is held back until chip enable has been low for `ACC_LAT` sampled edges and output enable for `OE_LAT` sampled edges. While the valid flag is low, the data output is forced to zero.

Top module: `otp_rom`

## Requirements
- R1: While reset is asserted and on the first edge after it, the outputs are `standby`=1, `doutEn`=0, `dataValid`=0 and `dout`=0x00. After reset every location reads 0xFF.
- R2: If `ceN` is sampled high, then on that edge `standby` becomes 1 and `doutEn` becomes 0, whatever `oeN`, `vppOn` and `sigSel` are.
- R3: If `ceN` is sampled low with `oeN` high, then `standby` becomes 0 and `doutEn` becomes 0.
- R4: If `ceN` and `oeN` are sampled low, `doutEn` becomes 1 on that edge. `dataValid` becomes 1 on the first edge at which `ceN` has been sampled low on `ACC_LAT` consecutive edges and `oeN` on `OE_LAT` consecutive edges. With `vppOn`=0 and `sigSel`=0, `dout` is then the byte stored at `addr`.
- R5: Whenever `dataValid` is 0, `dout` is 0x00.
- R6: Program mode is `vppOn`=1, `ceN`=0 and `oeN`=1. On each edge in this mode the byte at `addr` becomes its old value ANDed with `din`.
- R7: Programming never turns a 0 bit into a 1.
- R8: Program-inhibit is `vppOn`=1 with `ceN`=1. It leaves the array unchanged.
- R9: Program-verify is `vppOn`=1, `ceN`=0 and `oeN`=0. It drives the stored byte under the R4 timing and does not write.
- R10: Identification read is `vppOn`=0, `sigSel`=1 and both enables low. It returns `MFR_CODE` (default 0x20) when `addr[0]`=0 and `DEV_CODE` (default 0x04) when `addr[0]`=1, in place of array data.
- R11: A sampled `eraseStb` sets every location to 0xFF and takes priority over a program write on the same edge.
- R12: With `vppOn`=0, a cycle with `ceN` low and `oeN` high writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| vppOn | input | 1 | Programming supply present |
| sigSel | input | 1 | Select identification code instead of the array |
| din | input | 8 | Program data |
| eraseStb | input | 1 | Erase whole array to ones |
| dout | output | 8 | Read data, zero when not valid |
| doutEn | output | 1 | Tri-state enable for dout |
| dataValid | output | 1 | dout holds valid data |
| standby | output | 1 | Device deselected |

## Verification
The four outputs are registered, and each one reflects the inputs sampled at the previous rising edge. `standby` and `doutEn` follow the enables one edge later. A write changes the array at the edge on which it is sampled, so a read on the next cycle returns the new byte. `dataValid` rises only after the latency counters reach their limits, which is three edges after a cold chip-enable fall with the defaults, or one edge after an output-enable fall once chip enable has been low for long enough. The bench changes inputs on the falling edge and compares outputs at the next falling edge, half a period after the edge that loaded them. The latency cases are held for several vectors in a row, and each intermediate cycle is checked for `dataValid`=0 and `dout`=0.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_PROGRAM,
    MODE_VERIFY,
    MODE_SIGNATURE,
    MODE_READ
  } otpMode_t;

  typedef struct packed {
    logic wrEn;     // AND din into the addressed byte
    logic eraseAll; // set the whole array to ones
    logic selSig;   // output source is the identification code
    logic loadOut;  // output register takes data this edge
  } otpStrobe_t;

endpackage

// File: rtl/otp_ctrl.sv
module otp_ctrl #(
  parameter int ACC_LAT = 3,
  parameter int OE_LAT  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceN,
  input  logic                 oeN,
  input  logic                 vppOn,
  input  logic                 sigSel,
  input  logic                 eraseStb,
  output otp_pkg::otpStrobe_t  strb,
  output logic                 doutEn,
  output logic                 dataValid,
  output logic                 standby
);
  import otp_pkg::*;

  localparam int CE_W = (ACC_LAT < 1) ? 1 : $clog2(ACC_LAT + 1);
  localparam int OE_W = (OE_LAT < 1) ? 1 : $clog2(OE_LAT + 1);
  localparam logic [CE_W-1:0] CE_MAX = CE_W'(ACC_LAT);
  localparam logic [OE_W-1:0] OE_MAX = OE_W'(OE_LAT);

  otpMode_t        mode;
  logic [CE_W-1:0] ceCnt, ceCntNext;
  logic [OE_W-1:0] oeCnt, oeCntNext;
  logic            readLike;
  logic            validNext;

  // Mode decode; the programming supply takes priority over the signature flag
  always_comb begin
    if (ceN)                 mode = MODE_STANDBY;
    else if (oeN && vppOn)   mode = MODE_PROGRAM;
    else if (oeN)            mode = MODE_DISABLE;
    else if (vppOn)          mode = MODE_VERIFY;
    else if (sigSel)         mode = MODE_SIGNATURE;
    else                     mode = MODE_READ;
  end

  assign readLike = (mode == MODE_READ) || (mode == MODE_VERIFY) ||
                    (mode == MODE_SIGNATURE);

  // Saturating counters of consecutive sampled-low edges
  always_comb begin
    if (ceN)                  ceCntNext = '0;
    else if (ceCnt >= CE_MAX) ceCntNext = CE_MAX;
    else                      ceCntNext = ceCnt + 1'b1;

    if (ceN || oeN)           oeCntNext = '0;
    else if (oeCnt >= OE_MAX) oeCntNext = OE_MAX;
    else                      oeCntNext = oeCnt + 1'b1;
  end

  assign validNext = readLike && (ceCntNext >= CE_MAX) && (oeCntNext >= OE_MAX);

  always_comb begin
    strb.eraseAll = eraseStb;
    strb.wrEn     = (mode == MODE_PROGRAM) && !eraseStb;
    strb.selSig   = (mode == MODE_SIGNATURE);
    strb.loadOut  = validNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceCnt     <= '0;
      oeCnt     <= '0;
      doutEn    <= 1'b0;
      dataValid <= 1'b0;
      standby   <= 1'b1;
    end else begin
      ceCnt     <= ceCntNext;
      oeCnt     <= oeCntNext;
      doutEn    <= readLike;
      dataValid <= validNext;
      standby   <= (mode == MODE_STANDBY);
    end
  end

endmodule

// File: rtl/otp_datapath.sv
module otp_datapath #(
  parameter int                       ADDR_W   = 6,
  parameter logic [otp_pkg::BYTE_W-1:0] MFR_CODE = 8'h20,
  parameter logic [otp_pkg::BYTE_W-1:0] DEV_CODE = 8'h04
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [otp_pkg::BYTE_W-1:0] din,
  input  otp_pkg::otpStrobe_t        strb,
  output logic [otp_pkg::BYTE_W-1:0] dout
);
  import otp_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];
  logic [BYTE_W-1:0] sigByte;
  logic [BYTE_W-1:0] arrayByte;

  assign sigByte   = addr[0] ? DEV_CODE : MFR_CODE;
  assign arrayByte = cells[addr];

  // One register per location; reset and erase both return to all ones
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rstN || strb.eraseAll)
        cells[g] <= '1;
      else if (strb.wrEn && (addr == ADDR_W'(g)))
        cells[g] <= cells[g] & din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      dout <= '0;
    else if (strb.loadOut)
      dout <= strb.selSig ? sigByte : arrayByte;
    else
      dout <= '0;
  end

endmodule

// File: rtl/otp_rom.sv
module otp_rom #(
  parameter int         ADDR_W   = 6,
  parameter int         ACC_LAT  = 3,
  parameter int         OE_LAT   = 1,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              vppOn,
  input  logic              sigSel,
  input  logic [7:0]        din,
  input  logic              eraseStb,
  output logic [7:0]        dout,
  output logic              doutEn,
  output logic              dataValid,
  output logic              standby
);
  import otp_pkg::*;

  otpStrobe_t strb;

  otp_ctrl #(.ACC_LAT(ACC_LAT), .OE_LAT(OE_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .vppOn(vppOn),
    .sigSel(sigSel), .eraseStb(eraseStb), .strb(strb),
    .doutEn(doutEn), .dataValid(dataValid), .standby(standby)
  );

  otp_datapath #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .din(din), .strb(strb), .dout(dout)
  );

endmodule

// File: rtl/otp_rom_chk.sv
module otp_rom_chk #(
  parameter int         ADDR_W   = 6,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'h04
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              ceN,
  input logic              oeN,
  input logic              vppOn,
  input logic              sigSel,
  input logic [7:0]        dout,
  input logic              doutEn,
  input logic              dataValid,
  input logic              standby
);

  p_standby_r2: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (standby && !doutEn));

  p_disable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeN) |=> (!standby && !doutEn));

  p_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN) |=> doutEn);

  p_valid_needs_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> doutEn);

  p_zero_when_invalid_r5: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> (dout == 8'h00));

  p_sig_mfr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !vppOn && sigSel && !addr[0]) |=> (!dataValid || dout == MFR_CODE));

  p_sig_dev_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !oeN && !vppOn && sigSel && addr[0]) |=> (!dataValid || dout == DEV_CODE));

endmodule

bind otp_rom otp_rom_chk #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN), .vppOn(vppOn),
  .sigSel(sigSel), .dout(dout), .doutEn(doutEn), .dataValid(dataValid),
  .standby(standby)
);

// File: tb/sim_otp_rom.sv
module sim_otp_rom;

  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] addr;
  logic       ceN, oeN, vppOn, sigSel, eraseStb;
  logic [7:0] din;
  logic [7:0] dout;
  logic       doutEn, dataValid, standby;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  otp_rom u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .ceN(ceN), .oeN(oeN), .vppOn(vppOn),
    .sigSel(sigSel), .din(din), .eraseStb(eraseStb), .dout(dout),
    .doutEn(doutEn), .dataValid(dataValid), .standby(standby)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       ceN, oeN, vpp, sig, er;
    logic [5:0] addr;
    logic [7:0] din;
    logic       en, val, sb;
    logic [7:0] dout;
  } vec_t;

  // One vector per cycle; outputs are compared half a cycle after the loading edge
  localparam vec_t VEC [0:20] = '{
    '{4'd2,  1'b1,1'b1,1'b0,1'b0,1'b0, 6'd0, 8'h00, 1'b0,1'b0,1'b1, 8'h00}, // R2 idle standby
    '{4'd6,  1'b0,1'b1,1'b1,1'b0,1'b0, 6'd5, 8'hA5, 1'b0,1'b0,1'b0, 8'h00}, // R6 program A5
    '{4'd6,  1'b0,1'b1,1'b1,1'b0,1'b0, 6'd5, 8'hF0, 1'b0,1'b0,1'b0, 8'h00}, // R6 AND F0 -> A0
    '{4'd9,  1'b0,1'b0,1'b1,1'b0,1'b0, 6'd5, 8'h00, 1'b1,1'b1,1'b0, 8'hA0}, // R9 verify
    '{4'd7,  1'b0,1'b1,1'b1,1'b0,1'b0, 6'd5, 8'hFF, 1'b0,1'b0,1'b0, 8'h00}, // R7 try FF
    '{4'd7,  1'b0,1'b0,1'b0,1'b0,1'b0, 6'd5, 8'h00, 1'b1,1'b1,1'b0, 8'hA0}, // R7 still A0
    '{4'd4,  1'b0,1'b0,1'b0,1'b0,1'b0, 6'd6, 8'h00, 1'b1,1'b1,1'b0, 8'hFF}, // R4 blank read
    '{4'd10, 1'b0,1'b0,1'b0,1'b1,1'b0, 6'd0, 8'h00, 1'b1,1'b1,1'b0, 8'h20}, // R10 mfr
    '{4'd10, 1'b0,1'b0,1'b0,1'b1,1'b0, 6'd1, 8'h00, 1'b1,1'b1,1'b0, 8'h04}, // R10 dev
    '{4'd10, 1'b0,1'b0,1'b0,1'b1,1'b0, 6'd2, 8'h00, 1'b1,1'b1,1'b0, 8'h20}, // R10 even addr
    '{4'd3,  1'b0,1'b1,1'b0,1'b0,1'b0, 6'd6, 8'h00, 1'b0,1'b0,1'b0, 8'h00}, // R3 R12 disable
    '{4'd8,  1'b1,1'b0,1'b1,1'b0,1'b0, 6'd6, 8'h00, 1'b0,1'b0,1'b1, 8'h00}, // R8 inhibit, R2
    '{4'd2,  1'b1,1'b1,1'b0,1'b0,1'b0, 6'd6, 8'h00, 1'b0,1'b0,1'b1, 8'h00}, // R2
    '{4'd5,  1'b0,1'b0,1'b0,1'b0,1'b0, 6'd6, 8'h00, 1'b1,1'b0,1'b0, 8'h00}, // R5 latency 1
    '{4'd5,  1'b0,1'b0,1'b0,1'b0,1'b0, 6'd6, 8'h00, 1'b1,1'b0,1'b0, 8'h00}, // R5 latency 2
    '{4'd12, 1'b0,1'b0,1'b0,1'b0,1'b0, 6'd6, 8'h00, 1'b1,1'b1,1'b0, 8'hFF}, // R4 R8 R12 FF
    '{4'd11, 1'b0,1'b1,1'b1,1'b0,1'b1, 6'd7, 8'h3C, 1'b0,1'b0,1'b0, 8'h00}, // R11 erase+prog
    '{4'd11, 1'b0,1'b0,1'b0,1'b0,1'b0, 6'd5, 8'h00, 1'b1,1'b1,1'b0, 8'hFF}, // R11 loc 5 erased
    '{4'd11, 1'b0,1'b0,1'b0,1'b0,1'b0, 6'd7, 8'h00, 1'b1,1'b1,1'b0, 8'hFF}, // R11 erase wins
    '{4'd3,  1'b0,1'b1,1'b0,1'b0,1'b0, 6'd7, 8'h00, 1'b0,1'b0,1'b0, 8'h00}, // R3
    '{4'd4,  1'b0,1'b0,1'b0,1'b0,1'b0, 6'd7, 8'h00, 1'b1,1'b1,1'b0, 8'hFF}  // R4 OE-only latency
  };

  task automatic drive(input logic c, input logic o, input logic v, input logic s,
                       input logic e, input logic [5:0] a, input logic [7:0] d);
    ceN = c; oeN = o; vppOn = v; sigSel = s; eraseStb = e; addr = a; din = d;
  endtask

  task automatic expectOut(input string tag, input logic en, input logic val,
                           input logic sb, input logic [7:0] dv);
    checks++;
    if (doutEn !== en || dataValid !== val || standby !== sb || dout !== dv) begin
      errors++;
      $display("FAIL %s: actual en=%b val=%b sb=%b dout=%h expected en=%b val=%b sb=%b dout=%h",
               tag, doutEn, dataValid, standby, dout, en, val, sb, dv);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 8'h00);
    repeat (3) @(negedge clk);
    expectOut("R1 reset", 1'b0, 1'b0, 1'b1, 8'h00);
    rstN = 1'b1;
    for (int i = 0; i <= 20; i++) begin
      drive(VEC[i].ceN, VEC[i].oeN, VEC[i].vpp, VEC[i].sig, VEC[i].er, VEC[i].addr, VEC[i].din);
      @(negedge clk);
      expectOut($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].en, VEC[i].val, VEC[i].sb, VEC[i].dout);
    end

    // R6: clear a whole byte, read it back with chip enable still low
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd3, 8'h00);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3, 8'h00);
    @(negedge clk);
    expectOut("R6 byte cleared", 1'b1, 1'b1, 1'b0, 8'h00);

    // R1: reset in the middle of a read, then the array is blank again
    rstN = 1'b0;
    @(negedge clk);
    expectOut("R1 reset mid-read", 1'b0, 1'b0, 1'b1, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R5 first read edge after reset", 1'b1, 1'b0, 1'b0, 8'h00);
    repeat (2) @(negedge clk);
    expectOut("R1 array blank after reset", 1'b1, 1'b1, 1'b0, 8'hFF);

    done = 1'b1;
    finishRun();
  end

endmodule